// File: doc/BRIEF.md
# Ring Oscillator PUF Response Evaluator

This block turns a bank of free-running ring oscillators into single-bit responses for challenge-response authentication. A challenge names two oscillators, one for each of two selectors. The block counts the rising edges of both chosen oscillators over a window of system clocks and sets the response bit by which of the two ran faster. Manufacturing spread makes each oscillator's frequency unique, so the same challenge gives different answers on different dies. The number of distinct challenges is bounded by the number of oscillator pairings.

The oscillator signals are asynchronous. Each one passes through a two-flop synchronizer and a rising-edge detector, so all counting happens in the system clock domain. A user presents a challenge and a window length, then pulses `start`. `busy` stays high while the measurement runs. `done` pulses once when `resp`, `tie` and `invalid` carry the new result. That result is held until the next evaluation completes.

Top module: `ro_puf_eval`

## Requirements
- R1: `challenge[IDX_W-1:0]` selects oscillator A and `challenge[2*IDX_W-1:IDX_W]` selects oscillator B, where IDX_W = ceil(log2 NUM_OSC). When `start` is sampled high while idle, the challenge and `win_len` are captured.
- R2: Every oscillator input passes through a two-flop synchronizer and a rising-edge detector. Each detected rising edge of a selected oscillator inside the window adds one to that selector's counter.
- R3: Both counters clear when a start is accepted. They count for exactly `win_len` system clocks and then freeze together. A `win_len` of 0 counts nothing.
- R4: For two different oscillators, `resp` is 1 when the count for A is greater than the count for B, and 0 otherwise.
- R5: When the two counts are equal and the oscillators are different, `resp` is 0 and `tie` is 1. Otherwise `tie` is 0.
- R6: When both fields name the same oscillator, `invalid` is 1, `resp` is 0 and `tie` is 0.
- R7: `start` is sampled on clock edge E0. `busy` is high from the cycle after E0. `done` is high for exactly one cycle after edge E0+`win_len`+2, and in that cycle `busy` is already low. `resp`, `tie` and `invalid` change only together with `done`.
- R8: A `start` pulse while `busy` is high has no effect. It does not change the running challenge, the window or the timing of `done`, and it produces no additional `done`.
- R9: During and after a synchronous active-high reset, `busy`, `done`, `resp`, `tie` and `invalid` are 0.
- R10: Swapping the two fields of a challenge whose counts differ inverts `resp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_in | input | NUM_OSC | Asynchronous ring oscillator outputs |
| start | input | 1 | Starts an evaluation when idle |
| challenge | input | 2*IDX_W | Bits [IDX_W-1:0] select oscillator A, bits [2*IDX_W-1:IDX_W] select oscillator B |
| win_len | input | WIN_W | Measurement window in system clocks |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| resp | output | 1 | Response bit: 1 when A counted more edges than B |
| tie | output | 1 | Counts were equal |
| invalid | output | 1 | Both fields named the same oscillator |

## Verification
Each result is due a fixed number of clocks after the accepting edge: `busy` one clock later, and `done` together with `resp`, `tie` and `invalid` exactly `win_len`+2 clocks later. When the driver starts an evaluation, it records the cycle in which `done` must show, alongside the expected result bits. The monitor compares the cycle of every `done` pulse with that record, so a window of the wrong length or an extra pipeline stage shows up as a timing failure. Windows of 0, 100 and 2000 clocks are run, so the timing check sees different window lengths. Oscillator periods are spread widely enough that two thousand clocks give a clear count difference between any two oscillators, which makes the expected response independent of phase.

// File: rtl/ro_puf_pkg.sv
`timescale 1ns/1ps
package ro_puf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_CMP  = 2'd2
  } eval_state_t;

  localparam int NUM_SEL = 2;
endpackage

// File: rtl/ro_edge_sync.sv
`timescale 1ns/1ps
module ro_edge_sync #(
  parameter int NUM_OSC = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_OSC-1:0] osc_in,
  output logic [NUM_OSC-1:0] rise
);
  for (genvar i = 0; i < NUM_OSC; i++) begin : g_lane
    logic meta_q;
    logic sync_q;
    logic prev_q;
    logic rise_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
        rise_q <= 1'b0;
      end else begin
        meta_q <= osc_in[i];
        sync_q <= meta_q;
        prev_q <= sync_q;
        rise_q <= sync_q & ~prev_q;
      end
    end

    assign rise[i] = rise_q;

    // R2
    rise_gap_chk: assert property (@(posedge clk) disable iff (rst)
      rise[i] |=> !rise[i]);
  end
endmodule

// File: rtl/ro_pair_counter.sv
`timescale 1ns/1ps
module ro_pair_counter #(
  parameter int NUM_OSC = 8,
  parameter int IDX_W   = 3,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_OSC-1:0] rise,
  input  logic [IDX_W-1:0]   idx,
  input  logic               clr,
  input  logic               en,
  output logic [CNT_W-1:0]   cnt
);
  localparam logic [IDX_W:0] OSC_LIM = NUM_OSC[IDX_W:0];

  logic sel_rise;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    sel_rise = 1'b0;
    if ({1'b0, idx} < OSC_LIM) sel_rise = rise[idx];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (en && sel_rise) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt = cnt_q;

  // R3
  freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !en) |=> $stable(cnt));

  // R2
  step_chk: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/ro_window_ctrl.sv
`timescale 1ns/1ps
module ro_window_ctrl
  import ro_puf_pkg::*;
#(
  parameter int WIN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIN_W-1:0] win_len,
  output logic             accept,
  output logic             cnt_en,
  output logic             cmp_go,
  output logic             busy
);
  eval_state_t      state_q;
  logic [WIN_W-1:0] rem_q;
  logic             busy_q;

  assign accept = (state_q == ST_IDLE) && start;
  assign cnt_en = (state_q == ST_RUN) && (rem_q != '0);
  assign cmp_go = (state_q == ST_CMP);
  assign busy   = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      busy_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_RUN;
            rem_q   <= win_len;
            busy_q  <= 1'b1;
          end
        end
        ST_RUN: begin
          if (rem_q == '0) state_q <= ST_CMP;
          else rem_q <= rem_q - 1'b1;
        end
        ST_CMP: begin
          state_q <= ST_IDLE;
          busy_q  <= 1'b0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R7
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy);

  // R8
  run_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_en |=> (busy && !accept));
endmodule

// File: rtl/ro_compare.sv
`timescale 1ns/1ps
module ro_compare #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic             same_idx,
  input  logic [CNT_W-1:0] cnt_a,
  input  logic [CNT_W-1:0] cnt_b,
  output logic             done,
  output logic             resp,
  output logic             tie,
  output logic             invalid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      done    <= 1'b0;
      resp    <= 1'b0;
      tie     <= 1'b0;
      invalid <= 1'b0;
    end else begin
      done <= go;
      if (go) begin
        if (same_idx) begin
          invalid <= 1'b1;
          resp    <= 1'b0;
          tie     <= 1'b0;
        end else begin
          invalid <= 1'b0;
          resp    <= (cnt_a > cnt_b);
          tie     <= (cnt_a == cnt_b);
        end
      end
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !go |=> ($stable(resp) && $stable(tie) && $stable(invalid)));

  // R5
  tie_resp_chk: assert property (@(posedge clk) disable iff (rst)
    tie |-> !resp);

  // R6
  invalid_excl_chk: assert property (@(posedge clk) disable iff (rst)
    invalid |-> (!resp && !tie));
endmodule

// File: rtl/ro_puf_eval.sv
`timescale 1ns/1ps
module ro_puf_eval
  import ro_puf_pkg::*;
#(
  parameter int NUM_OSC = 8,
  parameter int WIN_W   = 16,
  parameter int IDX_W   = (NUM_OSC > 1) ? $clog2(NUM_OSC) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_OSC-1:0]   osc_in,
  input  logic                 start,
  input  logic [2*IDX_W-1:0]   challenge,
  input  logic [WIN_W-1:0]     win_len,
  output logic                 busy,
  output logic                 done,
  output logic                 resp,
  output logic                 tie,
  output logic                 invalid
);
  localparam int CNT_W = WIN_W;

  logic [NUM_OSC-1:0] rise;
  logic               accept;
  logic               cnt_en;
  logic               cmp_go;
  logic [IDX_W-1:0]   idx_q [NUM_SEL];
  logic [CNT_W-1:0]   cnt   [NUM_SEL];
  logic               same_idx;

  ro_edge_sync #(.NUM_OSC(NUM_OSC)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .osc_in (osc_in),
    .rise   (rise)
  );

  ro_window_ctrl #(.WIN_W(WIN_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .win_len (win_len),
    .accept  (accept),
    .cnt_en  (cnt_en),
    .cmp_go  (cmp_go),
    .busy    (busy)
  );

  for (genvar s = 0; s < NUM_SEL; s++) begin : g_sel
    always_ff @(posedge clk) begin
      if (rst) idx_q[s] <= '0;
      else if (accept) idx_q[s] <= challenge[s*IDX_W +: IDX_W];
    end

    ro_pair_counter #(
      .NUM_OSC (NUM_OSC),
      .IDX_W   (IDX_W),
      .CNT_W   (CNT_W)
    ) u_cnt (
      .clk  (clk),
      .rst  (rst),
      .rise (rise),
      .idx  (idx_q[s]),
      .clr  (accept),
      .en   (cnt_en),
      .cnt  (cnt[s])
    );
  end

  assign same_idx = (idx_q[0] == idx_q[1]);

  ro_compare #(.CNT_W(CNT_W)) u_cmp (
    .clk      (clk),
    .rst      (rst),
    .go       (cmp_go),
    .same_idx (same_idx),
    .cnt_a    (cnt[0]),
    .cnt_b    (cnt[1]),
    .done     (done),
    .resp     (resp),
    .tie      (tie),
    .invalid  (invalid)
  );

  // R8
  sel_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !cmp_go) |=> ($stable(idx_q[0]) && $stable(idx_q[1])));

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: tb/sim_ro_puf_eval.sv
`timescale 1ns/1ps
module sim_ro_puf_eval;
  localparam int NUM_OSC = 8;
  localparam int WIN_W   = 16;
  localparam int IDX_W   = 3;

  typedef struct {
    bit    resp;
    bit    tie;
    bit    inv;
    int    due;
    string req;
  } exp_t;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [NUM_OSC-1:0] osc;
  logic               start = 1'b0;
  logic [2*IDX_W-1:0] challenge = '0;
  logic [WIN_W-1:0]   win_len = '0;
  logic               busy, done, resp, tie, invalid;
  logic               freeze = 1'b0;

  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  int   n_done = 0;
  exp_t q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  for (genvar i = 0; i < NUM_OSC; i++) begin : g_osc
    logic o = 1'b0;
    initial begin
      #(3 * i);
      forever begin
        #(40 * (i + 1) + 7);
        if (!freeze) o = ~o;
      end
    end
    assign osc[i] = o;
  end

  ro_puf_eval #(.NUM_OSC(NUM_OSC), .WIN_W(WIN_W)) u0 (
    .clk       (clk),
    .rst       (rst),
    .osc_in    (osc),
    .start     (start),
    .challenge (challenge),
    .win_len   (win_len),
    .busy      (busy),
    .done      (done),
    .resp      (resp),
    .tie       (tie),
    .invalid   (invalid)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: pop the expected item on every done pulse
  always @(negedge clk) begin
    if (!rst && done) begin
      n_done++;
      if (q.size() == 0) begin
        check("R8 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(e.req, resp, e.resp);
        check("R5 tie", tie, e.tie);
        check("R6 invalid", invalid, e.inv);
        check("R3/R7 done cycle", cyc, e.due);
        check("R7 busy low at done", busy, 0);
      end
    end
  end

  // driver: start an evaluation and push the expected result
  task automatic run_eval(input int a, input int b, input int w,
                          input bit er, input bit et, input bit ei,
                          input string req, input bit poke);
    exp_t e;
    @(negedge clk);
    challenge = {b[IDX_W-1:0], a[IDX_W-1:0]};
    win_len   = w[WIN_W-1:0];
    start     = 1'b1;
    e.resp = er; e.tie = et; e.inv = ei; e.req = req;
    e.due  = cyc + w + 3;
    q.push_back(e);
    @(negedge clk);
    start = 1'b0;
    check("R7 busy after start", busy, 1);
    if (poke) begin
      repeat (5) @(negedge clk);
      // R8: a start while busy, with a challenge that would flip the answer
      challenge = {a[IDX_W-1:0], b[IDX_W-1:0]};
      win_len   = 16'd3;
      start     = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    bit timeout;
    timeout = 1'b0;
    fork
      begin
        repeat (4) @(negedge clk);
        // R9 reset state
        check("R9 busy", busy, 0);
        check("R9 done", done, 0);
        check("R9 resp", resp, 0);
        check("R9 tie", tie, 0);
        check("R9 invalid", invalid, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 busy after release", busy, 0);

        // R1 R2 R4: lower index runs faster
        run_eval(1, 5, 2000, 1, 0, 0, "R1 resp field order", 0);
        run_eval(0, 7, 2000, 1, 0, 0, "R4 resp fast vs slow", 0);
        run_eval(6, 7, 2000, 1, 0, 0, "R2 resp adjacent pair", 0);
        // R10 swapped fields invert
        run_eval(5, 1, 2000, 0, 0, 0, "R10 swapped resp", 0);
        run_eval(7, 6, 2000, 0, 0, 0, "R10 swapped adjacent", 0);
        // R6 same oscillator
        run_eval(3, 3, 100, 0, 0, 1, "R6 resp on invalid", 0);
        // R3 zero window counts nothing
        run_eval(0, 4, 0, 0, 1, 0, "R3 zero window resp", 0);
        // R8 start while busy ignored
        run_eval(2, 4, 2000, 1, 0, 0, "R8 resp with busy start", 1);
        repeat (30) @(negedge clk);
        check("R8 done count", n_done, 8);
        // R5 frozen oscillators give equal counts
        freeze = 1'b1;
        repeat (20) @(negedge clk);
        run_eval(2, 6, 100, 0, 1, 0, "R5 tie resp", 0);
        freeze = 1'b0;
        repeat (20) @(negedge clk);
        // R6 invalid clears on next valid result
        run_eval(4, 0, 2000, 0, 0, 0, "R6 valid after invalid", 0);
        check("R7 total dones", n_done, 10);
      end
      begin
        repeat (200000) @(posedge clk);
        timeout = 1'b1;
      end
    join_any
    disable fork;
    if (timeout) check("watchdog", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule